// File: doc/BRIEF.md
# Accumulator Datapath with Toggling Link Flag

This block is the arithmetic and logic stage of a 16-bit accumulator processor. Each cycle it may accept one operation code together with the present accumulator, an operand fetched by the surrounding machine, and the present condition codes. One cycle later it returns the new accumulator, a value to be written back to memory (for stores and the memory increment), and the updated condition codes. Fetch, address generation and memory access belong to the enclosing processor.

The condition codes are a link bit L, a sign bit N, a zero bit Z and an I/O flag F. Arithmetic does not load L from the carry: a carry out of the adder flips L. Rotates move the 17-bit ring formed by L above the accumulator. Every operation has its own rule for which codes it updates, and Z always looks at all 16 bits of the result.

Top module: `acc_alu_core`

## Requirements
- R1: While reset is held and in the cycle after it, `out_valid_o` is 0 and `acc_o`, `mem_o`, `flags_o` are 0; with the default registered output, the result for an operation taken with `in_valid_o`=1 at a clock edge appears on the outputs right after the next edge, with `out_valid_o`=1, and `out_valid_o` is 0 after an edge where `in_valid_i` was 0.
- R2: Code bit layout is F=bit 3, Z=bit 2, N=bit 1, L=bit 0. Load byte (op 0) puts opnd bits 7:0 in the accumulator, sign-extended through bit 15; load word (op 1) copies the operand; both set N to result bit 15 and Z to (result==0) over 16 bits and leave L unchanged.
- R3: Add byte (op 4, operand byte sign-extended) and add word (op 5) write acc+operand; L is inverted when bit 16 of the 17-bit sum is 1, else kept; N and Z follow the result.
- R4: Compare byte (op 6, operand byte sign-extended) and compare word (op 7) form operand + (~acc) + 1; N and Z follow its low 16 bits, L is inverted when its bit 16 is 1; the accumulator is not changed.
- R5: AND byte (op 8, sign-extended byte) and AND word (op 9) write acc & operand, set N and Z, keep L.
- R6: Memory increment (op 10) puts opnd+1 on `mem_o`, keeps the accumulator, inverts L on carry out of bit 15 and sets N, Z from opnd+1; accumulator increment (op 11) writes acc+1 with the same code rule.
- R7: Negate (op 13) writes the two's complement of acc, inverts L only when the original acc was nonzero, and sets N and Z.
- R8: Complement (op 12) writes ~acc, inverts L, and sets N and Z from the new accumulator.
- R9: Clear (op 14) gives 0000 with N=0, Z=1; plus-one (op 15) gives 0001 with N=0, Z=0; both keep L. Minus-one (op 16) gives FFFF, inverts L, and sets N=1, Z=0.
- R10: Rotate right (op 17) gives acc={L,acc[15:1]} and L=acc[0]; rotate left (op 18) gives acc={acc[14:0],L} and L=acc[15]; both then set N=bit 15 and Z from the accumulator.
- R11: Complement-link (op 19) inverts L and changes nothing else; clear-codes (op 20) sets all four codes to 0 and keeps the accumulator.
- R12: Store byte (op 2) puts {00,acc[7:0]} on `mem_o`, store word (op 3) puts acc on `mem_o`; both keep the accumulator and all codes. All other operations drive `mem_o` to 0.
- R13: F is passed through by every operation except clear-codes; codes 21 to 31 change neither the accumulator nor any code and drive `mem_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 5 | Operation code |
| acc_i | input | DATA_W | Present accumulator |
| opnd_i | input | DATA_W | Effective operand (byte in the low half) |
| flags_i | input | 4 | Present codes {F,Z,N,L} |
| out_valid_o | output | 1 | Result outputs hold a new result |
| acc_o | output | DATA_W | New accumulator |
| mem_o | output | DATA_W | Value to write back to memory |
| flags_o | output | 4 | New codes {F,Z,N,L} |

## Verification
The assertions watch, on every result, the fixed-value operations (clear, minus-one), that compares and stores leave the accumulator alone, that stores keep all codes, that complement-link touches only L, that F survives everything but clear-codes, and that Z agrees with the accumulator for operations that write it. The carry-driven toggling of L, the sign extension of byte operands, the exact rotate ring, and negate's zero special case depend on operand values and are shown only by the bench's scenarios, which compare every result against an independent model, including back-to-back operations and idle gaps.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [4:0] {
      OP_LDB = 5'd0,
      OP_LDW = 5'd1,
      OP_STB = 5'd2,
      OP_STW = 5'd3,
      OP_ADB = 5'd4,
      OP_ADW = 5'd5,
      OP_CPB = 5'd6,
      OP_CPW = 5'd7,
      OP_ANB = 5'd8,
      OP_ANW = 5'd9,
      OP_INC = 5'd10,
      OP_IAC = 5'd11,
      OP_CMA = 5'd12,
      OP_NEG = 5'd13,
      OP_CLA = 5'd14,
      OP_PAC = 5'd15,
      OP_MAC = 5'd16,
      OP_RAR = 5'd17,
      OP_RAL = 5'd18,
      OP_CML = 5'd19,
      OP_CCC = 5'd20
   } alu_op_e;

   typedef struct packed {
      logic f;
      logic z;
      logic n;
      logic l;
   } cc_t;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   localparam int EXT_W = W + 1;

   logic [EXT_W-1:0] wide;

   always_comb begin
      wide   = {1'b0, a_i} + {1'b0, b_i} + {{(EXT_W-1){1'b0}}, cin_i};
      sum_o  = wide[W-1:0];
      cout_o = wide[W];
   end
endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate #(
   parameter int W = 16
) (
   input  logic [W-1:0] acc_i,
   input  logic         link_i,
   input  logic         left_i,
   output logic [W-1:0] acc_o,
   output logic         link_o
);
   always_comb begin
      if (left_i) begin
         acc_o  = {acc_i[W-2:0], link_i};
         link_o = acc_i[W-1];
      end else begin
         acc_o  = {link_i, acc_i[W-1:1]};
         link_o = acc_i[0];
      end
   end
endmodule

// File: rtl/acc_alu_codes.sv
module acc_alu_codes #(
   parameter int W      = 16,
   parameter int LANE_W = 8
) (
   input  logic [W-1:0] res_i,
   output logic         neg_o,
   output logic         zero_o
);
   localparam int LANES = W / LANE_W;

   logic [LANES-1:0] lane_nz;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_nz[g] = |res_i[g*LANE_W +: LANE_W];
   end

   assign neg_o  = res_i[W-1];
   assign zero_o = ~|lane_nz;
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_valid_i,
   input  logic [4:0]        op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [3:0]        flags_i,
   output logic              out_valid_o,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] mem_o,
   output logic [3:0]        flags_o
);
   localparam int HALF_W = DATA_W / 2;

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("acc_alu_core: DATA_W must be even and at least 4");
   end

   alu_op_e           op;
   cc_t               cc_in, base_cc, nxt_cc;
   logic [DATA_W-1:0] ext_byte;
   logic [DATA_W-1:0] add_a, add_b, add_sum;
   logic              add_cin, add_cout;
   logic [DATA_W-1:0] rot_acc;
   logic              rot_link;
   logic [DATA_W-1:0] nxt_acc, nxt_mem, code_src;
   logic              upd_nz, code_n, code_z;

   assign op       = alu_op_e'(op_i);
   assign cc_in    = cc_t'(flags_i);
   assign ext_byte = {{HALF_W{opnd_i[HALF_W-1]}}, opnd_i[HALF_W-1:0]};

   // adder operand steering
   always_comb begin
      add_a   = acc_i;
      add_b   = '0;
      add_cin = 1'b0;
      case (op)
         OP_ADB: add_b = ext_byte;
         OP_ADW: add_b = opnd_i;
         OP_CPB: begin add_a = ext_byte; add_b = ~acc_i; add_cin = 1'b1; end
         OP_CPW: begin add_a = opnd_i;   add_b = ~acc_i; add_cin = 1'b1; end
         OP_INC: begin add_a = opnd_i;   add_cin = 1'b1; end
         OP_IAC: add_cin = 1'b1;
         OP_NEG: begin add_a = ~acc_i;   add_cin = 1'b1; end
         default: ;
      endcase
   end

   acc_alu_adder #(.W(DATA_W)) i_adder (
      .a_i   (add_a),
      .b_i   (add_b),
      .cin_i (add_cin),
      .sum_o (add_sum),
      .cout_o(add_cout)
   );

   acc_alu_rotate #(.W(DATA_W)) i_rotate (
      .acc_i (acc_i),
      .link_i(cc_in.l),
      .left_i(op == OP_RAL),
      .acc_o (rot_acc),
      .link_o(rot_link)
   );

   // per-operation result and code rules
   always_comb begin
      nxt_acc  = acc_i;
      nxt_mem  = '0;
      base_cc  = cc_in;
      upd_nz   = 1'b0;
      code_src = acc_i;
      case (op)
         OP_LDB: begin nxt_acc = ext_byte; upd_nz = 1'b1; code_src = ext_byte; end
         OP_LDW: begin nxt_acc = opnd_i;   upd_nz = 1'b1; code_src = opnd_i;   end
         OP_STB: nxt_mem = {{HALF_W{1'b0}}, acc_i[HALF_W-1:0]};
         OP_STW: nxt_mem = acc_i;
         OP_ADB, OP_ADW, OP_IAC: begin
            nxt_acc   = add_sum;
            base_cc.l = cc_in.l ^ add_cout;
            upd_nz    = 1'b1;
            code_src  = add_sum;
         end
         OP_CPB, OP_CPW: begin
            base_cc.l = cc_in.l ^ add_cout;
            upd_nz    = 1'b1;
            code_src  = add_sum;
         end
         OP_ANB: begin nxt_acc = acc_i & ext_byte; upd_nz = 1'b1; code_src = acc_i & ext_byte; end
         OP_ANW: begin nxt_acc = acc_i & opnd_i;   upd_nz = 1'b1; code_src = acc_i & opnd_i;   end
         OP_INC: begin
            nxt_mem   = add_sum;
            base_cc.l = cc_in.l ^ add_cout;
            upd_nz    = 1'b1;
            code_src  = add_sum;
         end
         OP_CMA: begin
            nxt_acc   = ~acc_i;
            base_cc.l = ~cc_in.l;
            upd_nz    = 1'b1;
            code_src  = ~acc_i;
         end
         OP_NEG: begin
            nxt_acc   = add_sum;
            base_cc.l = cc_in.l ^ (|acc_i);
            upd_nz    = 1'b1;
            code_src  = add_sum;
         end
         OP_CLA: begin nxt_acc = '0; base_cc.n = 1'b0; base_cc.z = 1'b1; end
         OP_PAC: begin
            nxt_acc   = {{(DATA_W-1){1'b0}}, 1'b1};
            base_cc.n = 1'b0;
            base_cc.z = 1'b0;
         end
         OP_MAC: begin
            nxt_acc   = '1;
            base_cc.l = ~cc_in.l;
            base_cc.n = 1'b1;
            base_cc.z = 1'b0;
         end
         OP_RAR, OP_RAL: begin
            nxt_acc   = rot_acc;
            base_cc.l = rot_link;
            upd_nz    = 1'b1;
            code_src  = rot_acc;
         end
         OP_CML: base_cc.l = ~cc_in.l;
         OP_CCC: base_cc = '0;
         default: ;
      endcase
   end

   acc_alu_codes #(.W(DATA_W), .LANE_W(HALF_W)) i_codes (
      .res_i (code_src),
      .neg_o (code_n),
      .zero_o(code_z)
   );

   always_comb begin
      nxt_cc = base_cc;
      if (upd_nz) begin
         nxt_cc.n = code_n;
         nxt_cc.z = code_z;
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            out_valid_o <= 1'b0;
            acc_o       <= '0;
            mem_o       <= '0;
            flags_o     <= '0;
         end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
               acc_o   <= nxt_acc;
               mem_o   <= nxt_mem;
               flags_o <= nxt_cc;
            end
         end
      end

      AST_CLEAR_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(in_valid_i && op_i == OP_CLA) |->
            (acc_o == '0 && flags_o[2] && !flags_o[1] && flags_o[0] == $past(flags_i[0]))) // R9
         else $error("clear result wrong");

      AST_MINUS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(in_valid_i && op_i == OP_MAC) |->
            (acc_o == '1 && flags_o[1] && !flags_o[2] && flags_o[0] != $past(flags_i[0]))) // R9
         else $error("minus-one result wrong");

      AST_CMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(in_valid_i && (op_i == OP_CPB || op_i == OP_CPW)) |->
            acc_o == $past(acc_i)) // R4
         else $error("compare wrote accumulator");

      AST_STORE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(in_valid_i && (op_i == OP_STB || op_i == OP_STW)) |->
            (flags_o == $past(flags_i) && acc_o == $past(acc_i))) // R12
         else $error("store changed state");

      AST_LINK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(in_valid_i && op_i == OP_CML) |->
            (acc_o == $past(acc_i) && flags_o[3:1] == $past(flags_i[3:1])
             && flags_o[0] != $past(flags_i[0]))) // R11
         else $error("complement-link touched more than L");

      AST_F_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(in_valid_i && op_i != OP_CCC) |-> flags_o[3] == $past(flags_i[3])) // R13
         else $error("F flag changed");

      AST_Z_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(in_valid_i && (op_i == OP_LDB || op_i == OP_LDW || op_i == OP_ANB ||
                              op_i == OP_ANW || op_i == OP_ADW || op_i == OP_RAL)) |->
            flags_o[2] == (acc_o == '0)) // R2
         else $error("Z disagrees with accumulator");
   end else begin : g_comb
      assign out_valid_o = in_valid_i;
      assign acc_o       = nxt_acc;
      assign mem_o       = nxt_mem;
      assign flags_o     = nxt_cc;
   end

endmodule

// File: tb/test_acc_alu_core.sv
module test_acc_alu_core;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 16;
   localparam int WATCHDOG   = 20000;

   typedef struct {
      logic [W-1:0] acc;
      logic [W-1:0] mem;
      logic [3:0]   fl;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [4:0]   op = '0;
   logic [W-1:0] acc = '0;
   logic [W-1:0] opnd = '0;
   logic [3:0]   flags = '0;
   logic         out_valid;
   logic [W-1:0] acc_out, mem_out;
   logic [3:0]   flags_out;

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_alu_core i_acc_alu_core (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .in_valid_i (in_valid),
      .op_i       (op),
      .acc_i      (acc),
      .opnd_i     (opnd),
      .flags_i    (flags),
      .out_valid_o(out_valid),
      .acc_o      (acc_out),
      .mem_o      (mem_out),
      .flags_o    (flags_out)
   );

   // flag bits: 3=F 2=Z 1=N 0=L
   function automatic exp_t model(input logic [4:0] o, input logic [W-1:0] a,
                                  input logic [W-1:0] d, input logic [3:0] f);
      exp_t        e;
      logic [W:0]  s;
      logic [W-1:0] sx;
      logic        nz;
      sx    = {{8{d[7]}}, d[7:0]};
      e.acc = a;
      e.mem = '0;
      e.fl  = f;
      nz    = 1'b0;
      s     = '0;
      case (o)
         5'd0:  begin e.acc = sx; nz = 1; end
         5'd1:  begin e.acc = d;  nz = 1; end
         5'd2:  e.mem = {8'h00, a[7:0]};
         5'd3:  e.mem = a;
         5'd4:  begin s = {1'b0, a} + {1'b0, sx}; e.acc = s[W-1:0]; e.fl[0] = f[0] ^ s[W]; nz = 1; end
         5'd5:  begin s = {1'b0, a} + {1'b0, d};  e.acc = s[W-1:0]; e.fl[0] = f[0] ^ s[W]; nz = 1; end
         5'd6, 5'd7: begin
            s = {1'b0, (o == 5'd6) ? sx : d} + {1'b0, ~a} + 17'd1;
            e.fl[0] = f[0] ^ s[W];
            e.fl[1] = s[W-1];
            e.fl[2] = (s[W-1:0] == 0);
         end
         5'd8:  begin e.acc = a & sx; nz = 1; end
         5'd9:  begin e.acc = a & d;  nz = 1; end
         5'd10: begin
            s = {1'b0, d} + 17'd1;
            e.mem = s[W-1:0];
            e.fl[0] = f[0] ^ s[W];
            e.fl[1] = s[W-1];
            e.fl[2] = (s[W-1:0] == 0);
         end
         5'd11: begin s = {1'b0, a} + 17'd1; e.acc = s[W-1:0]; e.fl[0] = f[0] ^ s[W]; nz = 1; end
         5'd12: begin e.acc = ~a; e.fl[0] = ~f[0]; nz = 1; end
         5'd13: begin e.acc = 16'd0 - a; e.fl[0] = f[0] ^ (a != 0); nz = 1; end
         5'd14: begin e.acc = 16'h0000; e.fl[1] = 0; e.fl[2] = 1; end
         5'd15: begin e.acc = 16'h0001; e.fl[1] = 0; e.fl[2] = 0; end
         5'd16: begin e.acc = 16'hFFFF; e.fl[0] = ~f[0]; e.fl[1] = 1; e.fl[2] = 0; end
         5'd17: begin e.acc = {f[0], a[15:1]}; e.fl[0] = a[0];  nz = 1; end
         5'd18: begin e.acc = {a[14:0], f[0]}; e.fl[0] = a[15]; nz = 1; end
         5'd19: e.fl[0] = ~f[0];
         5'd20: e.fl = 4'b0000;
         default: ;
      endcase
      if (nz) begin
         e.fl[1] = e.acc[W-1];
         e.fl[2] = (e.acc == 0);
      end
      return e;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // driver: one operation per clock, expected result queued
   task automatic issue(input logic [4:0] o, input logic [W-1:0] a,
                        input logic [W-1:0] d, input logic [3:0] f, input string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      op = o; acc = a; opnd = d; flags = f;
      e = model(o, a, d, f);
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         op = 5'd31; acc = 16'hDEAD; opnd = 16'hBEEF; flags = 4'hF;
      end
   endtask

   // monitor: R1 latency - a result is expected exactly one edge after issue
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R1", "unexpected out_valid", {15'd0, out_valid}, 16'd0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check(acc_out == e.acc, e.tag, "acc", acc_out, e.acc);
               check(mem_out == e.mem, e.tag, "mem", mem_out, e.mem);
               check(flags_out == e.fl, e.tag, "flags", {12'd0, flags_out}, {12'd0, e.fl});
            end
         end else if (rst_n && sb_q.size() != 0) begin
            check(1'b0, "R1", "result missing", 16'd0, 16'd1);
            void'(sb_q.pop_front());
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         check(1'b0, "WATCHDOG", "timeout", 16'd0, 16'd0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(out_valid == 1'b0 && acc_out == 0 && mem_out == 0 && flags_out == 0,
            "R1", "reset outputs", acc_out, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && flags_out == 0, "R1", "after reset", {15'd0, out_valid}, 16'd0);

      // R2 loads
      issue(5'd0, 16'h1234, 16'h5580, 4'b0001, "R2");
      issue(5'd0, 16'h1234, 16'h7F00, 4'b0001, "R2");
      issue(5'd0, 16'h0000, 16'hFF7F, 4'b0000, "R2");
      issue(5'd1, 16'h0001, 16'h8000, 4'b1000, "R2");
      issue(5'd1, 16'h5555, 16'h0000, 4'b0000, "R2");
      idle(2);
      // R3 adds
      issue(5'd5, 16'hFFFF, 16'h0001, 4'b0000, "R3");
      issue(5'd5, 16'hFFFF, 16'h0001, 4'b0001, "R3");
      issue(5'd5, 16'h1000, 16'h2000, 4'b0001, "R3");
      issue(5'd4, 16'h0005, 16'h00FF, 4'b0000, "R3");
      issue(5'd4, 16'h7FFF, 16'h3301, 4'b0000, "R3");
      // R4 compares
      issue(5'd7, 16'h1234, 16'h1234, 4'b0000, "R4");
      issue(5'd7, 16'h0000, 16'h0010, 4'b0001, "R4");
      issue(5'd7, 16'h0020, 16'h0010, 4'b0000, "R4");
      issue(5'd6, 16'hFFFE, 16'hAAFE, 4'b0000, "R4");
      idle(1);
      // R5 and
      issue(5'd9, 16'hF0F0, 16'h0F0F, 4'b0001, "R5");
      issue(5'd8, 16'hABCD, 16'h0080, 4'b0000, "R5");
      // R6 increments
      issue(5'd10, 16'h4444, 16'hFFFF, 4'b0000, "R6");
      issue(5'd10, 16'h4444, 16'h7FFF, 4'b0001, "R6");
      issue(5'd11, 16'hFFFF, 16'h0000, 4'b0001, "R6");
      issue(5'd11, 16'h0041, 16'h0000, 4'b0000, "R6");
      // R7 negate
      issue(5'd13, 16'h0000, 16'h0000, 4'b0001, "R7");
      issue(5'd13, 16'h0005, 16'h0000, 4'b0001, "R7");
      issue(5'd13, 16'h8000, 16'h0000, 4'b0000, "R7");
      // R8 complement
      issue(5'd12, 16'hFFFF, 16'h0000, 4'b0000, "R8");
      issue(5'd12, 16'h00FF, 16'h0000, 4'b0001, "R8");
      idle(3);
      // R9 constants
      issue(5'd14, 16'h1234, 16'h0000, 4'b0011, "R9");
      issue(5'd15, 16'h8000, 16'h0000, 4'b0101, "R9");
      issue(5'd16, 16'h0000, 16'h0000, 4'b0100, "R9");
      issue(5'd16, 16'h0000, 16'h0000, 4'b0001, "R9");
      // R10 rotates
      issue(5'd17, 16'h0001, 16'h0000, 4'b0000, "R10");
      issue(5'd17, 16'h0002, 16'h0000, 4'b0001, "R10");
      issue(5'd18, 16'h8000, 16'h0000, 4'b0000, "R10");
      issue(5'd18, 16'h4001, 16'h0000, 4'b0001, "R10");
      // R11 link ops
      issue(5'd19, 16'h9999, 16'h0000, 4'b1110, "R11");
      issue(5'd19, 16'h9999, 16'h0000, 4'b0001, "R11");
      issue(5'd20, 16'h7777, 16'h0000, 4'b1111, "R11");
      // R12 stores
      issue(5'd2, 16'hABCD, 16'h1111, 4'b1011, "R12");
      issue(5'd3, 16'hABCD, 16'h1111, 4'b0100, "R12");
      // R13 F kept, undefined codes
      issue(5'd5, 16'h0001, 16'h0002, 4'b1000, "R13");
      issue(5'd21, 16'h1357, 16'h2468, 4'b1011, "R13");
      issue(5'd31, 16'h0000, 16'hFFFF, 4'b0101, "R13");
      idle(4);
      check(sb_q.size() == 0, "R1", "queue drained", sb_q.size(), 16'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule